// File: doc/BRIEF.md
# Interrupt and Page-Fault Mode Controller

This block owns the interrupt and fault portion of a processor's 32-bit status word and decides, once per instruction, whether the sequencer should branch into interrupt microcode or fault microcode. Six request lines feed a priority encoder. An INT1 cycle-start strobe marks the point where the pending and enable bits are sampled. An active-low fault line from the memory management unit forces a supervisor mode that outranks ordinary interrupt handling. The sequencer samples that line in every T1 or T2 cycle, and a fault seen during T1 also raises a restart request.

The block also remaps the register index used by the rest of the datapath. While a supervisor mode is active, accesses to the link register (index 13) are sent to one of two alternate registers. Physical index 16 is alternate A, used under the fault-owned mode. Physical index 17 is alternate B, used under the interrupt-owned mode. All other indices pass through unchanged.

The controller is a four-state machine:
- MS_IDLE is normal running.
- MS_IRQ_ENTRY is a one-cycle interrupt entry.
- MS_FLT_WAIT holds a pending fault until the next INT1 rise.
- MS_FLT_ENTRY is a one-cycle fault entry.

Its transitions are:
- idle to irq-entry on an INT1 rise with IP and IE set.
- any non-waiting state to flt-wait when the fault line is low.
- flt-wait to flt-entry on an INT1 rise.
- each entry state back to idle, or directly into another entry or into flt-wait when the corresponding condition holds in that cycle.

Top module: `irq_fault_ctrl`

## Requirements
- R1: After reset the status word reads 0. Its layout is: VID at bits 10:8, IP at bit 11, PE at bit 12, IE at bit 13, SUP0 at bit 14, SUP1 at bit 15, AUX at bits 31:16. Bits 7:0 always read 0.
- R2: A software write (`sw_we`=1) loads VID, PE, IE, SUP0, SUP1 and AUX from the matching bit positions of `sw_wdata`. Written values of bit 11 and bits 7:0 have no effect.
- R3: IP equals the OR of `irq_req` sampled at the previous clock edge.
- R4: On a rising edge of `int1_stb` with IP=1 and IE=1 and no fault pending, the controller takes an interrupt. IE becomes 0, SUP1 becomes 1, and VID takes the number n of the highest active line, where line n is `irq_req[n-1]`. `entry_sel` reads 1 for exactly the next cycle.
- R5: An INT1 rise with IE=0 changes nothing. Holding `int1_stb` high without a new rise never starts an entry, even after IE is set.
- R6: A low `fault_n` at a clock edge sets SUP0 and raises `fault_pending`. `fault_pending` stays high until the next INT1 rise.
- R7: A fault sampled while `t1_phase`=1 raises `restart_req`, which holds through the fault entry cycle and then drops. A fault seen only in T2 leaves it 0.
- R8: An INT1 rise while a fault is pending services the fault whatever IE is, and ahead of any interrupt request. The controller clears `fault_pending`, writes VID=7, clears IE, keeps SUP0 at 1 and leaves SUP1 unchanged. `entry_sel` reads 2 for the next cycle.
- R9: `lk_idx_out` is 16 when `lk_idx_in`=13 and SUP0=1. It is 17 when `lk_idx_in`=13, SUP0=0 and SUP1=1. Otherwise it is `lk_idx_in`.
- R10: When a hardware event and a software write hit the same edge, the hardware values of IE, SUP0, SUP1 and VID win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 6 | Request lines, bit n-1 is line n |
| fault_n | input | 1 | Active-low page-fault line |
| t1_phase | input | 1 | 1 during a T1 (execute) cycle |
| int1_stb | input | 1 | INT1 cycle-start strobe, acted on at its rising edge |
| sw_we | input | 1 | Status word write enable |
| sw_wdata | input | 32 | Status word write data |
| lk_idx_in | input | 4 | Logical register index |
| stat_word | output | 32 | Status word |
| entry_sel | output | 2 | Microcode entry: 0 none, 1 interrupt, 2 fault |
| fault_pending | output | 1 | Fault captured and awaiting service |
| restart_req | output | 1 | Faulting instruction must be restarted |
| lk_idx_out | output | 5 | Physical register index after remapping |

## Verification
A wrong state register shows up one cycle after the triggering edge. It appears as a missing or doubled `entry_sel` pulse, or as `fault_pending` falling without an INT1 rise. A wrong VID, IE or SUP bit is visible in `stat_word` on the cycle after the INT1 rise. A wrong supervisor bit also misroutes index 13 on `lk_idx_out` in that same cycle, so remap errors show up without delay. A restart flag that is cleared early or left stuck is caught on the cycles around the fault entry pulse.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    localparam int STAT_W    = 32;
    localparam int VID_W     = 3;
    localparam int VID_LSB   = 8;
    localparam int IP_BIT    = 11;
    localparam int PE_BIT    = 12;
    localparam int IE_BIT    = 13;
    localparam int SUP0_BIT  = 14;
    localparam int SUP1_BIT  = 15;
    localparam int AUX_LSB   = 16;
    localparam int AUX_W     = 16;
    localparam int FAULT_VID = 7;

    typedef enum logic [1:0] {
        MS_IDLE      = 2'd0,
        MS_IRQ_ENTRY = 2'd1,
        MS_FLT_WAIT  = 2'd2,
        MS_FLT_ENTRY = 2'd3
    } mode_state_t;

    typedef enum logic [1:0] {
        ENT_NONE  = 2'd0,
        ENT_IRQ   = 2'd1,
        ENT_FAULT = 2'd2
    } entry_t;
endpackage

// File: rtl/ifc_prio_enc.sv
module ifc_prio_enc #(
    parameter int N = 6,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] code
);
    // Ripple chain: each stage overrides lower-numbered winners.
    logic [W-1:0] stage [N+1];

    assign stage[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_stage
        assign stage[i+1] = req[i] ? W'(i + 1) : stage[i];
    end

    assign code = stage[N];
endmodule

// File: rtl/ifc_rise_det.sv
module ifc_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/ifc_mode_fsm.sv
module ifc_mode_fsm
    import ifc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flt_seen,
    input  logic       t1_phase,
    input  logic       int1_rise,
    input  logic       ip,
    input  logic       ie,
    output logic       take_irq,
    output logic       take_flt,
    output logic [1:0] entry_sel,
    output logic       fault_pending,
    output logic       restart_req
);
    mode_state_t state_q, state_d;
    logic        restart_q;
    logic        irq_go;

    assign irq_go = int1_rise & ip & ie;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= state_d;
    end

    // Restart flag: set by a T1 fault, dropped after the fault entry cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                      restart_q <= 1'b0;
        else if (flt_seen && t1_phase)   restart_q <= 1'b1;
        else if (state_q == MS_FLT_ENTRY) restart_q <= 1'b0;
    end

    // Next state and event pulses
    always_comb begin
        state_d  = state_q;
        take_irq = 1'b0;
        take_flt = 1'b0;
        unique case (state_q)
            MS_IDLE, MS_IRQ_ENTRY, MS_FLT_ENTRY: begin
                if (flt_seen) begin
                    state_d = MS_FLT_WAIT;
                end else if (irq_go) begin
                    state_d  = MS_IRQ_ENTRY;
                    take_irq = 1'b1;
                end else begin
                    state_d = MS_IDLE;
                end
            end
            MS_FLT_WAIT: begin
                if (int1_rise) begin
                    state_d  = MS_FLT_ENTRY;
                    take_flt = 1'b1;
                end
            end
            default: state_d = MS_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        entry_sel     = ENT_NONE;
        fault_pending = 1'b0;
        unique case (state_q)
            MS_IDLE:      entry_sel = ENT_NONE;
            MS_IRQ_ENTRY: entry_sel = ENT_IRQ;
            MS_FLT_WAIT:  fault_pending = 1'b1;
            MS_FLT_ENTRY: entry_sel = ENT_FAULT;
            default:      entry_sel = ENT_NONE;
        endcase
        restart_req = restart_q;
    end
endmodule

// File: rtl/ifc_status_reg.sv
module ifc_status_reg
    import ifc_pkg::*;
#(
    parameter int NUM_IRQ = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               sw_we,
    input  logic [STAT_W-1:0]  sw_wdata,
    input  logic               take_irq,
    input  logic               take_flt,
    input  logic               flt_seen,
    input  logic [VID_W-1:0]   win_vid,
    output logic [NUM_IRQ-1:0] req_q,
    output logic [STAT_W-1:0]  stat_word,
    output logic               ip,
    output logic               ie,
    output logic               sup0,
    output logic               sup1
);
    logic [VID_W-1:0] vid_q;
    logic             ip_q, pe_q, ie_q, sup0_q, sup1_q;
    logic [AUX_W-1:0] aux_q;
    logic             unused_wbits;

    assign unused_wbits = ^{sw_wdata[IP_BIT], sw_wdata[VID_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            ip_q   <= 1'b0;
            vid_q  <= '0;
            pe_q   <= 1'b0;
            ie_q   <= 1'b0;
            sup0_q <= 1'b0;
            sup1_q <= 1'b0;
            aux_q  <= '0;
        end else begin
            req_q <= irq_req;
            ip_q  <= |irq_req;
            if (sw_we) begin
                vid_q  <= sw_wdata[VID_LSB +: VID_W];
                pe_q   <= sw_wdata[PE_BIT];
                ie_q   <= sw_wdata[IE_BIT];
                sup0_q <= sw_wdata[SUP0_BIT];
                sup1_q <= sw_wdata[SUP1_BIT];
                aux_q  <= sw_wdata[AUX_LSB +: AUX_W];
            end
            // Hardware events override a same-cycle software write
            if (take_irq) begin
                ie_q   <= 1'b0;
                sup1_q <= 1'b1;
                vid_q  <= win_vid;
            end
            if (take_flt) begin
                ie_q   <= 1'b0;
                sup0_q <= 1'b1;
                vid_q  <= VID_W'(FAULT_VID);
            end
            if (flt_seen) sup0_q <= 1'b1;
        end
    end

    always_comb begin
        stat_word                     = '0;
        stat_word[VID_LSB +: VID_W]   = vid_q;
        stat_word[IP_BIT]             = ip_q;
        stat_word[PE_BIT]             = pe_q;
        stat_word[IE_BIT]             = ie_q;
        stat_word[SUP0_BIT]           = sup0_q;
        stat_word[SUP1_BIT]           = sup1_q;
        stat_word[AUX_LSB +: AUX_W]   = aux_q;
    end

    assign ip   = ip_q;
    assign ie   = ie_q;
    assign sup0 = sup0_q;
    assign sup1 = sup1_q;
endmodule

// File: rtl/ifc_bank_remap.sv
module ifc_bank_remap #(
    parameter int IDX_W    = 4,
    parameter int LINK_IDX = 13
) (
    input  logic [IDX_W-1:0] idx_in,
    input  logic             sup0,
    input  logic             sup1,
    output logic [IDX_W:0]   idx_out
);
    localparam logic [IDX_W:0] ALT_A = (IDX_W+1)'(2 ** IDX_W);
    localparam logic [IDX_W:0] ALT_B = (IDX_W+1)'(2 ** IDX_W + 1);

    logic is_link;
    assign is_link = (idx_in == IDX_W'(LINK_IDX));

    always_comb begin
        if (is_link && sup0)      idx_out = ALT_A;
        else if (is_link && sup1) idx_out = ALT_B;
        else                      idx_out = {1'b0, idx_in};
    end
endmodule

// File: rtl/irq_fault_ctrl.sv
module irq_fault_ctrl
    import ifc_pkg::*;
#(
    parameter int NUM_IRQ  = 6,
    parameter int IDX_W    = 4,
    parameter int LINK_IDX = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               fault_n,
    input  logic               t1_phase,
    input  logic               int1_stb,
    input  logic               sw_we,
    input  logic [STAT_W-1:0]  sw_wdata,
    input  logic [IDX_W-1:0]   lk_idx_in,
    output logic [STAT_W-1:0]  stat_word,
    output logic [1:0]         entry_sel,
    output logic               fault_pending,
    output logic               restart_req,
    output logic [IDX_W:0]     lk_idx_out
);
    logic               int1_rise;
    logic               flt_seen;
    logic               take_irq, take_flt;
    logic               ip, ie, sup0, sup1;
    logic [NUM_IRQ-1:0] req_q;
    logic [VID_W-1:0]   win_vid;

    assign flt_seen = ~fault_n;

    ifc_rise_det u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (int1_stb),
        .rise (int1_rise)
    );

    ifc_prio_enc #(.N(NUM_IRQ), .W(VID_W)) u_enc (
        .req (req_q),
        .code(win_vid)
    );

    ifc_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .flt_seen     (flt_seen),
        .t1_phase     (t1_phase),
        .int1_rise    (int1_rise),
        .ip           (ip),
        .ie           (ie),
        .take_irq     (take_irq),
        .take_flt     (take_flt),
        .entry_sel    (entry_sel),
        .fault_pending(fault_pending),
        .restart_req  (restart_req)
    );

    ifc_status_reg #(.NUM_IRQ(NUM_IRQ)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .take_irq (take_irq),
        .take_flt (take_flt),
        .flt_seen (flt_seen),
        .win_vid  (win_vid),
        .req_q    (req_q),
        .stat_word(stat_word),
        .ip       (ip),
        .ie       (ie),
        .sup0     (sup0),
        .sup1     (sup1)
    );

    ifc_bank_remap #(.IDX_W(IDX_W), .LINK_IDX(LINK_IDX)) u_remap (
        .idx_in (lk_idx_in),
        .sup0   (sup0),
        .sup1   (sup1),
        .idx_out(lk_idx_out)
    );
endmodule

// File: rtl/irq_fault_ctrl_chk.sv
module irq_fault_ctrl_chk
    import ifc_pkg::*;
#(
    parameter int NUM_IRQ  = 6,
    parameter int IDX_W    = 4,
    parameter int LINK_IDX = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fault_n,
    input logic               int1_stb,
    input logic [IDX_W-1:0]   lk_idx_in,
    input logic [STAT_W-1:0]  stat_word,
    input logic [1:0]         entry_sel,
    input logic               fault_pending,
    input logic               restart_req,
    input logic [IDX_W:0]     lk_idx_out
);
    localparam logic [IDX_W:0] ALT_A = (IDX_W+1)'(2 ** IDX_W);
    localparam logic [IDX_W:0] ALT_B = (IDX_W+1)'(2 ** IDX_W + 1);

    p_remap_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_idx_in == IDX_W'(LINK_IDX) && stat_word[SUP0_BIT]) |-> lk_idx_out == ALT_A);

    p_remap_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_idx_in == IDX_W'(LINK_IDX) && !stat_word[SUP0_BIT] && stat_word[SUP1_BIT])
        |-> lk_idx_out == ALT_B);

    p_fault_sup0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |=> (stat_word[SUP0_BIT] && fault_pending));

    p_irq_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        entry_sel == ENT_IRQ |-> (!stat_word[IE_BIT] && stat_word[SUP1_BIT]));

    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        entry_sel == ENT_IRQ |=> entry_sel != ENT_IRQ);

    p_flt_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        entry_sel == ENT_FAULT |-> (stat_word[VID_LSB +: VID_W] == VID_W'(FAULT_VID)
                                    && stat_word[SUP0_BIT] && !stat_word[IE_BIT]));

    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_pending && !(int1_stb && !$past(int1_stb))) |=> fault_pending);

    p_restart_scope_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> (fault_pending || entry_sel == ENT_FAULT));

    p_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[VID_LSB-1:0] == '0);
endmodule

bind irq_fault_ctrl irq_fault_ctrl_chk #(
    .NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W), .LINK_IDX(LINK_IDX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_n      (fault_n),
    .int1_stb     (int1_stb),
    .lk_idx_in    (lk_idx_in),
    .stat_word    (stat_word),
    .entry_sel    (entry_sel),
    .fault_pending(fault_pending),
    .restart_req  (restart_req),
    .lk_idx_out   (lk_idx_out)
);

// File: tb/irq_fault_ctrl_bench.sv
module irq_fault_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  irq_req;
    logic        fault_n, t1_phase, int1_stb, sw_we;
    logic [31:0] sw_wdata;
    logic [3:0]  lk_idx_in;
    logic [31:0] stat_word;
    logic [1:0]  entry_sel;
    logic        fault_pending, restart_req;
    logic [4:0]  lk_idx_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irq_fault_ctrl u_irq_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fault_n(fault_n),
        .t1_phase(t1_phase), .int1_stb(int1_stb), .sw_we(sw_we),
        .sw_wdata(sw_wdata), .lk_idx_in(lk_idx_in), .stat_word(stat_word),
        .entry_sel(entry_sel), .fault_pending(fault_pending),
        .restart_req(restart_req), .lk_idx_out(lk_idx_out)
    );

    // {sup0, sup1, idx[3:0], expected physical index[4:0]}
    localparam logic [10:0] REMAP_VEC [8] = '{
        {1'b0, 1'b0, 4'd13, 5'd13},
        {1'b1, 1'b0, 4'd13, 5'd16},
        {1'b0, 1'b1, 4'd13, 5'd17},
        {1'b1, 1'b1, 4'd13, 5'd16},
        {1'b1, 1'b1, 4'd5,  5'd5},
        {1'b0, 1'b1, 4'd6,  5'd6},
        {1'b1, 1'b0, 4'd0,  5'd0},
        {1'b0, 1'b0, 4'd15, 5'd15}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic sw_write(input logic [31:0] w);
        sw_we = 1'b1; sw_wdata = w;
        step();
        sw_we = 1'b0; sw_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; fault_n = 1'b1; t1_phase = 1'b0;
        int1_stb = 1'b0; sw_we = 1'b0; sw_wdata = '0; lk_idx_in = 4'd13;
        repeat (3) step();
        // R1: reset state
        chk("R1 reset stat", stat_word, 32'h0);
        chk("R1 reset entry", 32'(entry_sel), 32'd0);
        chk("R1 reset pend", 32'(fault_pending), 32'd0);
        chk("R1 reset restart", 32'(restart_req), 32'd0);
        rst_n = 1'b1;
        step();

        // R2 / R9: table of supervisor settings and lookups
        for (int i = 0; i < 8; i++) begin
            logic s0, s1;
            logic [3:0] ix;
            logic [4:0] ex;
            {s0, s1, ix, ex} = REMAP_VEC[i];
            sw_write({16'hA5C3, s1, s0, 1'b0, 1'b1, 1'b1, 3'b000, 8'hFF});
            lk_idx_in = ix;
            #1;
            chk("R9 remap", 32'(lk_idx_out), 32'(ex));
            chk("R2 write fields", stat_word,
                {16'hA5C3, s1, s0, 1'b0, 1'b1, 1'b0, 3'b000, 8'h00});
        end
        lk_idx_in = 4'd13;

        // R3: IP follows requests one edge later
        sw_write(32'h0000_2000);
        irq_req = 6'b000101;
        chk("R3 ip before edge", 32'(stat_word[11]), 32'd0);
        step();
        chk("R3 ip set", 32'(stat_word[11]), 32'd1);

        // R4: interrupt taken, highest line 3 wins
        int1_stb = 1'b1;
        step();
        chk("R4 entry irq", 32'(entry_sel), 32'd1);
        chk("R4 stat after take", stat_word, 32'h0000_8B00);
        chk("R9 remap sup1", 32'(lk_idx_out), 32'd17);
        step();
        chk("R4 entry one cycle", 32'(entry_sel), 32'd0);
        int1_stb = 1'b0;
        step();

        // R5: IE clear blocks entry
        irq_req = 6'b100001;
        step();
        int1_stb = 1'b1;
        step();
        chk("R5 no entry ie0", 32'(entry_sel), 32'd0);
        chk("R5 vid kept", 32'(stat_word[10:8]), 32'd3);
        // R5: level held high after IE set gives no entry
        sw_write(32'h0000_2000);
        step();
        chk("R5 level no entry", 32'(entry_sel), 32'd0);
        chk("R5 ie still set", 32'(stat_word[13]), 32'd1);
        int1_stb = 1'b0;
        step();
        int1_stb = 1'b1;
        step();
        chk("R4 entry line6", 32'(entry_sel), 32'd1);
        chk("R4 vid highest", 32'(stat_word[10:8]), 32'd6);
        int1_stb = 1'b0;
        step();

        // R2 / R9: software return clears supervisor bits
        sw_write(32'h0);
        chk("R9 remap normal", 32'(lk_idx_out), 32'd13);

        // R6 / R7: fault in T2
        t1_phase = 1'b0; fault_n = 1'b0;
        step();
        fault_n = 1'b1;
        chk("R6 sup0 set", 32'(stat_word[14]), 32'd1);
        chk("R6 pending", 32'(fault_pending), 32'd1);
        chk("R7 no restart t2", 32'(restart_req), 32'd0);
        chk("R9 remap sup0", 32'(lk_idx_out), 32'd16);
        step(); step();
        chk("R6 pending held", 32'(fault_pending), 32'd1);
        int1_stb = 1'b1;
        step();
        chk("R8 entry fault", 32'(entry_sel), 32'd2);
        chk("R8 vid 7", 32'(stat_word[10:8]), 32'd7);
        chk("R8 pending released", 32'(fault_pending), 32'd0);
        chk("R8 sup0 kept", 32'(stat_word[14]), 32'd1);
        int1_stb = 1'b0;
        step();
        chk("R8 entry ends", 32'(entry_sel), 32'd0);

        // R7 / R8 / R10: T1 fault, IE set and a request active
        sw_write(32'h0000_2000);
        irq_req = 6'b000010;
        step();
        t1_phase = 1'b1; fault_n = 1'b0;
        step();
        t1_phase = 1'b0; fault_n = 1'b1;
        chk("R7 restart set", 32'(restart_req), 32'd1);
        step(); step();
        chk("R7 restart held", 32'(restart_req), 32'd1);
        // R10: software clears SUP0 and IE at the same edge as the fault entry
        int1_stb = 1'b1; sw_we = 1'b1; sw_wdata = 32'h0000_2000;
        step();
        sw_we = 1'b0; sw_wdata = '0;
        chk("R8 fault beats irq", 32'(entry_sel), 32'd2);
        chk("R8 sup1 unchanged", 32'(stat_word[15]), 32'd0);
        chk("R10 hw wins ie", 32'(stat_word[13]), 32'd0);
        chk("R10 hw wins sup0", 32'(stat_word[14]), 32'd1);
        chk("R7 restart in entry", 32'(restart_req), 32'd1);
        int1_stb = 1'b0;
        step();
        chk("R7 restart dropped", 32'(restart_req), 32'd0);
        chk("R8 idle after", 32'(entry_sel), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule